// File: doc/BRIEF.md
# Outstanding Data-Miss Tracker with Issue Stall

This block lets a pipeline keep issuing after a data-cache load miss. Each miss the cache reports is written into a small table. A table entry holds the missing line address and the set of destination registers that wait for that line. Every issuing instruction presents up to two source-register tags and a flag that marks it as a load or store. The block raises `stall` in the same cycle when the instruction reads a register that a pending miss will write. It also raises `stall` when the instruction is a memory operation and every table entry is occupied.

When the memory side finishes a refill, it presents the index of the entry it has completed. That entry is released in the same cycle, so an instruction that waits only on it issues without a bubble. A second miss to a line that is already pending does not take a new entry. It adds its destination register to the existing entry. The cache arrays, the refill data path and the register file are outside this block.

Top module: `miss_tracker`

## Requirements
- R1: After reset no entry is pending, so a load or store issued in the first cycle after reset is not stalled.
- R2: Recording a miss never stalls by itself. An issuing instruction whose sources do not match any pending destination is not stalled while fewer than all entries are occupied, and `stall` is 0 whenever `iss_valid` is 0.
- R3: `stall` is 1 in the same cycle as issue when a source tag with its use bit set equals a destination of a pending entry. A matching tag whose use bit is 0 causes no stall.
- R4: A miss to a line that is not pending is taken by the lowest-numbered free entry. `miss_accept`=1, `miss_merged`=0 and `miss_idx` give that entry in the same cycle.
- R5: A miss to a line that an entry already holds merges into that entry: `miss_accept`=1, `miss_merged`=1, `miss_idx`=that entry. The merge occupies no other entry.
- R6: When all entries (two by default) are pending, an issuing load or store (`iss_is_mem`=1) is stalled.
- R7: A non-memory instruction (`iss_is_mem`=0) with no dependency is not stalled, even when all entries are pending.
- R8: `cmpl_valid` with `cmpl_idx` frees that entry and drops its destinations. Any stall caused only by that entry, whether a dependency or a full table, is released in the same cycle.
- R9: A miss that arrives when every entry is pending, with no line match and no completion, is refused with `miss_accept`=0 and is not recorded. Its destination then causes no stall.
- R10: A destination added by a merge causes a dependency stall just like the first destination of the entry.
- R11: An entry being completed in the current cycle counts as free for a new miss in that cycle. It is never a merge target, even if its line matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is issuing this cycle |
| iss_is_mem | input | 1 | The issuing instruction is a load or store |
| iss_src_tag | input | NSRC*TAG_W | Source register tags, packed by slot |
| iss_src_use | input | NSRC | Per-slot flag that the source is read |
| miss_req | input | 1 | The cache reports a data miss this cycle |
| miss_line | input | LINE_W | Line address of the miss |
| miss_dst | input | TAG_W | Destination register of the missing load |
| cmpl_valid | input | 1 | The memory side completes an entry this cycle |
| cmpl_idx | input | IDX_W | Index of the completed entry |
| stall | output | 1 | Hold the issuing instruction |
| miss_accept | output | 1 | The miss was recorded (allocated or merged) |
| miss_merged | output | 1 | The miss joined an existing entry |
| miss_idx | output | IDX_W | Entry index that holds the miss |

## Verification
The bench builds the block with its defaults: two entries, two source slots, 5-bit register tags and 10-bit line addresses. With two entries, the table fills after just two distinct-line misses. This makes the full-table stall, a refused third miss and a completion that frees a slot in the same cycle as a new allocation short sequences to reach. The 32-register tag space lets the bench pick clearly separate tags for merged destinations and for sources that do not depend on a miss.

// File: rtl/mt_pkg.sv
package mt_pkg;

    // Reason the issuing instruction is held
    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_DEP  = 2'd1,
        HOLD_FULL = 2'd2
    } hold_cause_e;

    // What happens to a reported miss
    typedef enum logic [1:0] {
        MISS_IDLE   = 2'd0,
        MISS_NEW    = 2'd1,
        MISS_JOIN   = 2'd2,
        MISS_REFUSE = 2'd3
    } miss_act_e;

    // Index width that stays legal for a single-entry table
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mt_entry.sv
module mt_entry #(
    parameter int LINE_W = 10,
    parameter int TAG_W  = 5,
    localparam int REGS  = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic              merge,
    input  logic              clear,
    input  logic [LINE_W-1:0] line_in,
    input  logic [TAG_W-1:0]  dst_in,
    output logic              valid,
    output logic [LINE_W-1:0] line,
    output logic [REGS-1:0]   dst_mask
);
    logic [REGS-1:0] dst_bit;

    assign dst_bit = REGS'(1) << dst_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            line     <= '0;
            dst_mask <= '0;
        end else if (alloc) begin
            valid    <= 1'b1;
            line     <= line_in;
            dst_mask <= dst_bit;
        end else if (clear) begin
            valid    <= 1'b0;
            dst_mask <= '0;
        end else if (merge) begin
            dst_mask <= dst_mask | dst_bit;
        end
    end
endmodule

// File: rtl/mt_alloc.sv
module mt_alloc
    import mt_pkg::*;
#(
    parameter int N      = 2,
    parameter int LINE_W = 10,
    localparam int IDX_W = idx_width(N)
) (
    input  logic              miss_req,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [N-1:0]      live,
    input  logic [LINE_W-1:0] ent_line [N],
    output logic [N-1:0]      alloc_vec,
    output logic [N-1:0]      merge_vec,
    output logic [IDX_W-1:0]  idx,
    output miss_act_e         act
);
    logic             hit_found;
    logic             free_found;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        hit_found  = 1'b0;
        free_found = 1'b0;
        hit_idx    = '0;
        free_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!hit_found && live[i] && ent_line[i] == miss_line) begin
                hit_found = 1'b1;
                hit_idx   = IDX_W'(i);
            end
            if (!free_found && !live[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        alloc_vec = '0;
        merge_vec = '0;
        idx       = '0;
        act       = MISS_IDLE;
        if (miss_req) begin
            if (hit_found) begin
                act                = MISS_JOIN;
                idx                = hit_idx;
                merge_vec[hit_idx] = 1'b1;
            end else if (free_found) begin
                act                 = MISS_NEW;
                idx                 = free_idx;
                alloc_vec[free_idx] = 1'b1;
            end else begin
                act = MISS_REFUSE;
            end
        end
    end
endmodule

// File: rtl/mt_hazard.sv
module mt_hazard
    import mt_pkg::*;
#(
    parameter int N     = 2,
    parameter int TAG_W = 5,
    parameter int NSRC  = 2,
    localparam int REGS = 1 << TAG_W
) (
    input  logic                       iss_valid,
    input  logic                       iss_is_mem,
    input  logic [NSRC-1:0][TAG_W-1:0] src_tag,
    input  logic [NSRC-1:0]            src_use,
    input  logic [N-1:0]               live,
    input  logic [REGS-1:0]            ent_mask [N],
    output hold_cause_e                cause
);
    logic [REGS-1:0] pending;
    logic            dep;

    always_comb begin
        pending = '0;
        for (int i = 0; i < N; i++) begin
            if (live[i]) pending = pending | ent_mask[i];
        end
        dep = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (src_use[k] && pending[src_tag[k]]) dep = 1'b1;
        end
        if (!iss_valid)                cause = HOLD_NONE;
        else if (dep)                  cause = HOLD_DEP;
        else if (iss_is_mem && &live)  cause = HOLD_FULL;
        else                           cause = HOLD_NONE;
    end
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
    import mt_pkg::*;
#(
    parameter int N      = 2,
    parameter int LINE_W = 10,
    parameter int TAG_W  = 5,
    parameter int NSRC   = 2,
    localparam int IDX_W = idx_width(N),
    localparam int REGS  = 1 << TAG_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       iss_valid,
    input  logic                       iss_is_mem,
    input  logic [NSRC-1:0][TAG_W-1:0] iss_src_tag,
    input  logic [NSRC-1:0]            iss_src_use,
    input  logic                       miss_req,
    input  logic [LINE_W-1:0]          miss_line,
    input  logic [TAG_W-1:0]           miss_dst,
    input  logic                       cmpl_valid,
    input  logic [IDX_W-1:0]           cmpl_idx,
    output logic                       stall,
    output logic                       miss_accept,
    output logic                       miss_merged,
    output logic [IDX_W-1:0]           miss_idx
);
    logic [N-1:0]      ent_valid;
    logic [N-1:0]      clear_vec;
    logic [N-1:0]      live;
    logic [N-1:0]      alloc_vec;
    logic [N-1:0]      merge_vec;
    logic [LINE_W-1:0] ent_line [N];
    logic [REGS-1:0]   ent_mask [N];
    miss_act_e         act;
    hold_cause_e       cause;

    // Completion frees its entry for this cycle's decisions
    always_comb begin
        clear_vec = '0;
        if (cmpl_valid) clear_vec[cmpl_idx] = 1'b1;
    end
    assign live = ent_valid & ~clear_vec;

    for (genvar g = 0; g < N; g++) begin : g_ent
        mt_entry #(.LINE_W(LINE_W), .TAG_W(TAG_W)) u_ent (
            .clk      (clk),
            .rst      (rst),
            .alloc    (alloc_vec[g]),
            .merge    (merge_vec[g]),
            .clear    (clear_vec[g]),
            .line_in  (miss_line),
            .dst_in   (miss_dst),
            .valid    (ent_valid[g]),
            .line     (ent_line[g]),
            .dst_mask (ent_mask[g])
        );
    end

    mt_alloc #(.N(N), .LINE_W(LINE_W)) u_alloc (
        .miss_req  (miss_req),
        .miss_line (miss_line),
        .live      (live),
        .ent_line  (ent_line),
        .alloc_vec (alloc_vec),
        .merge_vec (merge_vec),
        .idx       (miss_idx),
        .act       (act)
    );

    mt_hazard #(.N(N), .TAG_W(TAG_W), .NSRC(NSRC)) u_haz (
        .iss_valid  (iss_valid),
        .iss_is_mem (iss_is_mem),
        .src_tag    (iss_src_tag),
        .src_use    (iss_src_use),
        .live       (live),
        .ent_mask   (ent_mask),
        .cause      (cause)
    );

    assign stall       = (cause != HOLD_NONE);
    assign miss_accept = (act == MISS_NEW) || (act == MISS_JOIN);
    assign miss_merged = (act == MISS_JOIN);
endmodule

// File: rtl/miss_tracker_chk.sv
module miss_tracker_chk #(
    parameter int N     = 2,
    parameter int IDX_W = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic             iss_is_mem,
    input logic             miss_req,
    input logic             miss_accept,
    input logic             miss_merged,
    input logic [IDX_W-1:0] miss_idx,
    input logic             cmpl_valid,
    input logic [IDX_W-1:0] cmpl_idx,
    input logic             stall,
    input logic [N-1:0]     ent_valid
);
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ent_valid == '0);

    p_idle_no_stall_r2: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> !stall);

    p_new_entry_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (miss_accept && !miss_merged) |=> ent_valid[$past(miss_idx)]);

    p_merge_target_live_r5: assert property (@(posedge clk) disable iff (rst)
        miss_merged |-> (miss_accept && ent_valid[miss_idx]));

    p_full_mem_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_is_mem && (&ent_valid) && !cmpl_valid) |-> stall);

    p_cmpl_frees_r8: assert property (@(posedge clk) disable iff (rst)
        (cmpl_valid && !(miss_accept && !miss_merged && miss_idx == cmpl_idx))
        |=> !ent_valid[$past(cmpl_idx)]);

    p_refuse_only_full_r9: assert property (@(posedge clk) disable iff (rst)
        (miss_req && !miss_accept) |-> (&ent_valid));

    p_no_accept_without_req_r4: assert property (@(posedge clk) disable iff (rst)
        !miss_req |-> !miss_accept);
endmodule

bind miss_tracker miss_tracker_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .iss_valid   (iss_valid),
    .iss_is_mem  (iss_is_mem),
    .miss_req    (miss_req),
    .miss_accept (miss_accept),
    .miss_merged (miss_merged),
    .miss_idx    (miss_idx),
    .cmpl_valid  (cmpl_valid),
    .cmpl_idx    (cmpl_idx),
    .stall       (stall),
    .ent_valid   (ent_valid)
);

// File: tb/miss_tracker_bench.sv
`timescale 1ns/1ps
module miss_tracker_bench;
    localparam int N      = 2;
    localparam int LINE_W = 10;
    localparam int TAG_W  = 5;
    localparam int NSRC   = 2;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       iss_valid = 1'b0;
    logic                       iss_is_mem = 1'b0;
    logic [NSRC-1:0][TAG_W-1:0] iss_src_tag = '0;
    logic [NSRC-1:0]            iss_src_use = '0;
    logic                       miss_req = 1'b0;
    logic [LINE_W-1:0]          miss_line = '0;
    logic [TAG_W-1:0]           miss_dst = '0;
    logic                       cmpl_valid = 1'b0;
    logic [0:0]                 cmpl_idx = '0;
    logic                       stall;
    logic                       miss_accept;
    logic                       miss_merged;
    logic [0:0]                 miss_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic stall;
        logic has_miss;
        logic acc;
        logic idx;
        logic mrg;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    always #2 clk = ~clk;

    miss_tracker #(.N(N), .LINE_W(LINE_W), .TAG_W(TAG_W), .NSRC(NSRC)) u_miss_tracker (
        .clk         (clk),
        .rst         (rst),
        .iss_valid   (iss_valid),
        .iss_is_mem  (iss_is_mem),
        .iss_src_tag (iss_src_tag),
        .iss_src_use (iss_src_use),
        .miss_req    (miss_req),
        .miss_line   (miss_line),
        .miss_dst    (miss_dst),
        .cmpl_valid  (cmpl_valid),
        .cmpl_idx    (cmpl_idx),
        .stall       (stall),
        .miss_accept (miss_accept),
        .miss_merged (miss_merged),
        .miss_idx    (miss_idx)
    );

    // Driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(
        input logic iv, input logic mem,
        input logic [4:0] s0, input logic u0,
        input logic [4:0] s1, input logic u1,
        input logic mreq, input logic [9:0] ml, input logic [4:0] md,
        input logic cv, input logic ci,
        input logic e_stall, input logic e_acc, input logic e_idx, input logic e_mrg,
        input string tag);
        exp_t e;
        @(negedge clk);
        iss_valid      = iv;
        iss_is_mem     = mem;
        iss_src_tag[0] = s0;
        iss_src_use[0] = u0;
        iss_src_tag[1] = s1;
        iss_src_use[1] = u1;
        miss_req       = mreq;
        miss_line      = ml;
        miss_dst       = md;
        cmpl_valid     = cv;
        cmpl_idx       = ci;
        e.stall    = e_stall;
        e.has_miss = mreq;
        e.acc      = e_acc;
        e.idx      = e_idx;
        e.mrg      = e_mrg;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: samples after inputs settle, before the next rising edge
    always begin
        @(negedge clk);
        #1;
        if (tag_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (stall !== e.stall) begin
                errors++;
                $display("FAIL %s stall got %0b exp %0b", t, stall, e.stall);
            end
            if (e.has_miss) begin
                checks++;
                if (miss_accept !== e.acc) begin
                    errors++;
                    $display("FAIL %s miss_accept got %0b exp %0b", t, miss_accept, e.acc);
                end
                if (e.acc) begin
                    checks++;
                    if (miss_idx !== e.idx || miss_merged !== e.mrg) begin
                        errors++;
                        $display("FAIL %s idx/merged got %0d/%0b exp %0d/%0b",
                                 t, miss_idx, miss_merged, e.idx, e.mrg);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got hung exp finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        //   iv mem  s0 u0  s1 u1 mreq line  dst cv ci  stall acc idx mrg
        step(1, 1,  3, 1,  4, 1, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R1 mem op after reset");
        step(0, 0,  0, 0,  0, 0, 1, 10'h10, 5, 0, 0,  0, 1, 0, 0, "R4 first miss to entry 0");
        step(1, 1,  7, 1,  8, 1, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R2 independent mem op");
        step(1, 0,  5, 1,  0, 0, 0, 10'h0,  0, 0, 0,  1, 0, 0, 0, "R3 source hits pending dst");
        step(1, 0,  6, 1,  5, 0, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R3 unused slot ignored");
        step(0, 0,  0, 0,  0, 0, 1, 10'h10, 9, 0, 0,  0, 1, 0, 1, "R5 same line merges");
        step(1, 0,  1, 0,  9, 1, 0, 10'h0,  0, 0, 0,  1, 0, 0, 0, "R10 merged dst stalls");
        step(1, 1,  1, 1,  2, 1, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R5 merge used no entry");
        step(0, 0,  0, 0,  0, 0, 1, 10'h20, 12, 0, 0, 0, 1, 1, 0, "R4 second miss to entry 1");
        step(1, 1,  1, 1,  2, 1, 0, 10'h0,  0, 0, 0,  1, 0, 0, 0, "R6 full table mem stall");
        step(1, 0,  1, 1,  2, 1, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R7 non-mem full no stall");
        step(0, 0,  0, 0,  0, 0, 1, 10'h30, 14, 0, 0, 0, 0, 0, 0, "R9 miss refused when full");
        step(1, 0, 14, 1,  0, 0, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R9 refused dst not pending");
        step(1, 0, 12, 1,  0, 0, 0, 10'h0,  0, 0, 0,  1, 0, 0, 0, "R3 dep on entry 1");
        step(1, 0, 12, 1,  0, 0, 0, 10'h0,  0, 1, 1,  0, 0, 0, 0, "R8 completion releases dep");
        step(1, 1,  1, 1,  2, 1, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R8 entry 1 freed");
        step(0, 0,  0, 0,  0, 0, 1, 10'h50, 21, 0, 0, 0, 1, 1, 0, "R4 refill entry 1");
        step(0, 0,  0, 0,  0, 0, 1, 10'h10, 22, 1, 0, 0, 1, 0, 0, "R11 reuse completing entry");
        step(1, 0,  5, 1,  9, 1, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R11 old dsts dropped");
        step(1, 0,  3, 0, 22, 1, 0, 10'h0,  0, 0, 0,  1, 0, 0, 0, "R11 new dst pending");
        step(1, 1,  1, 1,  2, 1, 0, 10'h0,  0, 1, 1,  0, 0, 0, 0, "R8 completion releases full");
        step(1, 0, 21, 1,  0, 0, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R8 entry 1 dst dropped");
        step(1, 1, 22, 1,  0, 0, 0, 10'h0,  0, 1, 0,  0, 0, 0, 0, "R8 last completion");
        step(1, 1, 22, 1, 21, 1, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R2 empty table");
        step(0, 1, 22, 1,  0, 0, 0, 10'h0,  0, 0, 0,  0, 0, 0, 0, "R2 no issue no stall");
        @(negedge clk);
        iss_valid  = 1'b0;
        miss_req   = 1'b0;
        cmpl_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule